// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block produces the single reset line of a microcontroller supervisor. Two causes feed it. The first is a supply fault: a synchronized "supply good" flag comes from an external comparator, and while that flag is low the reset is held. When the supply comes back, the reset stays asserted for a fixed hold interval before it releases. The second cause is a watchdog. The chip-select line doubles as the watchdog input, and every falling edge on it restarts the watchdog count. If the watchdog is enabled and no falling edge arrives within the selected period, the block raises reset. It does this whether the line is stuck high or stuck low.

All timing is counted in ticks of a shared timebase, which a prescaler divides down from the system clock. The hold interval and the three watchdog periods are parameters in ticks. In silicon the defaults are scaled to about 200 ms for the hold and about 1.4 s, 600 ms and 200 ms for the periods. Simulation uses short counts. A watchdog reset lasts the same hold interval as a supply reset. After it releases, the watchdog starts again from zero. A parameter sets the polarity of the output. The analog detector and the output pad are outside this block.

Top module: `supply_watchdog_reset`

## Requirements
- R1: While `rstN` is low, and after it rises while `supplyOk` is still low, the reset output is active.
- R2: If `supplyOk` is sampled low on a clock edge, the reset output is active right after that same edge.
- R3: Once `supplyOk` returns high, reset stays active for `HOLD_TICKS` timebase ticks. A tick occurs every `TICK_DIV` clocks. Reset then releases after the edge that carries the last tick.
- R4: A falling edge on `csWdi` (high on one clock edge, low on the next) restarts the watchdog count. Kicks spaced less than one period apart never cause a reset.
- R5: With the watchdog armed, reset is asserted after the selected number of ticks with no falling edge on `csWdi`. This holds whether the line stays high or stays low.
- R6: `wdPeriodSel` selects the period: 2'b00 gives `WD_TICKS_LONG`, 2'b01 gives `WD_TICKS_MID`, 2'b10 gives `WD_TICKS_SHORT`, and 2'b11 disables the watchdog.
- R7: While `wdEnable` is low, the watchdog never asserts reset.
- R8: A watchdog reset lasts `HOLD_TICKS` ticks and then releases.
- R9: If `supplyOk` drops during a watchdog reset, the hold interval restarts in full once the supply returns.
- R10: With `ACTIVE_HIGH` = 0 the output is low while reset is active. With `ACTIVE_HIGH` = 1 it is high while reset is active.
- R11: A kick that falls in the same cycle as the tick that would expire the watchdog wins. No reset follows, and a full new period starts.
- R12: The watchdog count is held at zero while reset is active. After any reset releases, a full period elapses before the next watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the timebase is derived from it |
| rstN | input | 1 | Asynchronous active-low power-on reset of the logic |
| supplyOk | input | 1 | Synchronized flag, high while the supply is above its trip level |
| csWdi | input | 1 | Chip-select line; a falling edge kicks the watchdog |
| wdEnable | input | 1 | Watchdog enable from the status register |
| wdPeriodSel | input | 2 | Watchdog period select from the status register |
| resetOut | output | 1 | Reset output; polarity set by `ACTIVE_HIGH` |

## Verification
A watchdog kick and a watchdog expiry can land on the same clock edge. Here the kick must win and start a fresh period. The bench provokes this with its own tick-accurate model of the requirements. It waits until the model shows the count one tick short of the period, with the next edge carrying a tick, and drives the falling edge into exactly that cycle. It then requires that reset stays inactive for a full new period. A supply drop during a watchdog hold is the second overlap. It is judged by measuring that the hold afterwards runs its whole length.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;

  typedef enum logic [1:0] {
    ST_FAULT = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } swrState_t;

  // control -> datapath
  typedef struct packed {
    logic holdRun;   // hold counter may count; cleared otherwise
    logic wdRun;     // watchdog counter may count; cleared otherwise
  } swrStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic tick;      // one-cycle timebase tick
    logic kick;      // falling edge seen on the chip-select line
    logic holdDone;  // last tick of the hold interval
    logic wdDue;     // watchdog period expired without a kick
  } swrStatus_t;

endpackage

// File: rtl/swr_datapath.sv
`timescale 1ns/1ps
module swr_datapath
  import swr_pkg::*;
#(
  parameter int TICK_DIV       = 4,
  parameter int HOLD_TICKS     = 8,
  parameter int WD_TICKS_LONG  = 24,
  parameter int WD_TICKS_MID   = 10,
  parameter int WD_TICKS_SHORT = 4,
  localparam int WD_MAX_A = (WD_TICKS_LONG > WD_TICKS_MID) ? WD_TICKS_LONG : WD_TICKS_MID,
  localparam int WD_MAX   = (WD_MAX_A > WD_TICKS_SHORT) ? WD_MAX_A : WD_TICKS_SHORT,
  localparam int CNT_W    = $clog2(WD_MAX + 1),
  localparam int PRE_W    = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1,
  localparam int HOLD_W   = $clog2(HOLD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csWdi,
  input  logic             wdEnable,
  input  logic [1:0]       wdPeriodSel,
  input  swrStrobe_t       strobe,
  output swrStatus_t       status,
  output logic [CNT_W-1:0] wdCount
);

  logic [PRE_W-1:0]  preCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [CNT_W-1:0]  wdLimit;
  logic              csPrev;
  logic              tick;
  logic              kick;
  logic              wdArmed;
  logic              holdDone;
  logic              wdDue;

  // free-running timebase prescaler
  assign tick = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // falling-edge detector on the chip-select / watchdog line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csPrev <= 1'b0;
    else       csPrev <= csWdi;
  end

  assign kick = csPrev & ~csWdi;

  // period decode; code 2'b11 disarms the watchdog
  assign wdArmed = wdEnable & (wdPeriodSel != 2'b11);

  always_comb begin
    case (wdPeriodSel)
      2'b00:   wdLimit = CNT_W'(WD_TICKS_LONG);
      2'b01:   wdLimit = CNT_W'(WD_TICKS_MID);
      default: wdLimit = CNT_W'(WD_TICKS_SHORT);
    endcase
  end

  // hold interval counter
  assign holdDone = strobe.holdRun & tick & (holdCnt == HOLD_W'(HOLD_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            holdCnt <= '0;
    else if (!strobe.holdRun || holdDone) holdCnt <= '0;
    else if (tick)                        holdCnt <= holdCnt + 1'b1;
  end

  // watchdog counter; a kick in the expiry cycle suppresses the expiry
  assign wdDue = strobe.wdRun & wdArmed & tick & ~kick & (wdCount >= wdLimit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           wdCount <= '0;
    else if (!strobe.wdRun || !wdArmed || kick || wdDue) wdCount <= '0;
    else if (tick)                                       wdCount <= wdCount + 1'b1;
  end

  assign status = '{tick: tick, kick: kick, holdDone: holdDone, wdDue: wdDue};

endmodule

// File: rtl/swr_control.sv
`timescale 1ns/1ps
module swr_control
  import swr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  swrStatus_t status,
  output swrStrobe_t strobe,
  output logic       resetActive
);

  swrState_t state;
  swrState_t nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_FAULT: if (supplyOk) nextState = ST_HOLD;
      ST_HOLD: begin
        if (!supplyOk)           nextState = ST_FAULT;
        else if (status.holdDone) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (!supplyOk)         nextState = ST_FAULT;
        else if (status.wdDue) nextState = ST_HOLD;
      end
      default: nextState = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FAULT;
    else       state <= nextState;
  end

  assign strobe.holdRun = (state == ST_HOLD) & supplyOk;
  assign strobe.wdRun   = (state == ST_RUN) & supplyOk;
  assign resetActive    = (state != ST_RUN);

endmodule

// File: rtl/supply_watchdog_reset.sv
`timescale 1ns/1ps
module supply_watchdog_reset
  import swr_pkg::*;
#(
  parameter bit ACTIVE_HIGH    = 1'b0,
  parameter int TICK_DIV       = 4,
  parameter int HOLD_TICKS     = 8,
  parameter int WD_TICKS_LONG  = 24,
  parameter int WD_TICKS_MID   = 10,
  parameter int WD_TICKS_SHORT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       csWdi,
  input  logic       wdEnable,
  input  logic [1:0] wdPeriodSel,
  output logic       resetOut
);

  localparam int WD_MAX_A = (WD_TICKS_LONG > WD_TICKS_MID) ? WD_TICKS_LONG : WD_TICKS_MID;
  localparam int WD_MAX   = (WD_MAX_A > WD_TICKS_SHORT) ? WD_MAX_A : WD_TICKS_SHORT;
  localparam int CNT_W    = $clog2(WD_MAX + 1);

  swrStrobe_t       strobe;
  swrStatus_t       status;
  logic [CNT_W-1:0] wdCount;
  logic             resetActive;

  swr_datapath #(
    .TICK_DIV      (TICK_DIV),
    .HOLD_TICKS    (HOLD_TICKS),
    .WD_TICKS_LONG (WD_TICKS_LONG),
    .WD_TICKS_MID  (WD_TICKS_MID),
    .WD_TICKS_SHORT(WD_TICKS_SHORT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .csWdi      (csWdi),
    .wdEnable   (wdEnable),
    .wdPeriodSel(wdPeriodSel),
    .strobe     (strobe),
    .status     (status),
    .wdCount    (wdCount)
  );

  swr_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .status     (status),
    .strobe     (strobe),
    .resetActive(resetActive)
  );

  generate
    if (ACTIVE_HIGH) begin : g_active_high
      assign resetOut = resetActive;
    end else begin : g_active_low
      assign resetOut = ~resetActive;
    end
  endgenerate

endmodule

// File: rtl/supply_watchdog_reset_chk.sv
`timescale 1ns/1ps
module supply_watchdog_reset_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             supplyOk,
  input logic             wdEnable,
  input logic [1:0]       wdPeriodSel,
  input logic             resetActive,
  input logic             tick,
  input logic             kick,
  input logic             holdDone,
  input logic [CNT_W-1:0] wdCount
);

  // R2: a low supply sample forces reset on the next cycle
  p_fault_forces_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> resetActive);

  // R3: release only at the end of a hold interval with the supply good
  p_release_after_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetActive) |-> ($past(supplyOk) && $past(holdDone)));

  // R4: a kick while running clears the watchdog count
  p_kick_restarts_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!resetActive && supplyOk && kick) |=> (wdCount == '0));

  // R7: a disarmed watchdog never trips a running block
  p_disarmed_no_trip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!resetActive && supplyOk && !(wdEnable && (wdPeriodSel != 2'b11))) |=> !resetActive);

  // R11: a watchdog trip comes from a tick without a kick in that cycle
  p_trip_needs_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(resetActive) && $past(supplyOk)) |-> ($past(tick) && !$past(kick)));

  // R12: the watchdog count stays cleared while reset is active
  p_count_clear_in_reset_r12: assert property (@(posedge clk) disable iff (!rstN)
    resetActive |-> (wdCount == '0));

endmodule

bind supply_watchdog_reset supply_watchdog_reset_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .wdEnable   (wdEnable),
  .wdPeriodSel(wdPeriodSel),
  .resetActive(resetActive),
  .tick       (status.tick),
  .kick       (status.kick),
  .holdDone   (status.holdDone),
  .wdCount    (wdCount)
);

// File: tb/supply_watchdog_reset_test.sv
`timescale 1ns/1ps
module supply_watchdog_reset_test;

  localparam int DIV = 4;
  localparam int H   = 8;
  localparam int WL  = 24;
  localparam int WM  = 10;
  localparam int WS  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       supplyOk = 1'b0;
  logic       csWdi = 1'b1;
  logic       wdEnable = 1'b1;
  logic [1:0] wdPeriodSel = 2'b10;
  logic       resetOutLo;
  logic       resetOutHi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit compareOn = 1'b0;

  always #5 clk = ~clk;

  supply_watchdog_reset #(
    .ACTIVE_HIGH(1'b0), .TICK_DIV(DIV), .HOLD_TICKS(H),
    .WD_TICKS_LONG(WL), .WD_TICKS_MID(WM), .WD_TICKS_SHORT(WS)
  ) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .csWdi(csWdi),
    .wdEnable(wdEnable), .wdPeriodSel(wdPeriodSel), .resetOut(resetOutLo)
  );

  supply_watchdog_reset #(
    .ACTIVE_HIGH(1'b1), .TICK_DIV(DIV), .HOLD_TICKS(H),
    .WD_TICKS_LONG(WL), .WD_TICKS_MID(WM), .WD_TICKS_SHORT(WS)
  ) uutHi (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .csWdi(csWdi),
    .wdEnable(wdEnable), .wdPeriodSel(wdPeriodSel), .resetOut(resetOutHi)
  );

  function automatic int limitOf(logic [1:0] sel);
    case (sel)
      2'b00:   return WL;
      2'b01:   return WM;
      default: return WS;
    endcase
  endfunction

  function bit active();
    return (resetOutLo == 1'b0);
  endfunction

  task automatic check(string req, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkRange(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // tick-accurate model of the requirements (state 0 fault, 1 hold, 2 run)
  int mPre = 0, mHold = 0, mWd = 0, mSt = 0, mLim = 0;
  bit mPrev = 1'b0, mTick = 1'b0, mKick = 1'b0, mArm = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; mHold = 0; mWd = 0; mSt = 0; mPrev = 1'b0;
    end else begin
      mTick = (mPre == DIV - 1);
      mKick = mPrev && !csWdi;
      mArm  = wdEnable && (wdPeriodSel != 2'b11);
      mLim  = limitOf(wdPeriodSel);
      mPre  = mTick ? 0 : mPre + 1;
      mPrev = csWdi;
      case (mSt)
        0: begin
          mHold = 0; mWd = 0;
          if (supplyOk) mSt = 1;
        end
        1: begin
          mWd = 0;
          if (!supplyOk) begin mSt = 0; mHold = 0; end
          else if (mTick) begin
            if (mHold == H - 1) begin mSt = 2; mHold = 0; end
            else mHold++;
          end
        end
        default: begin
          mHold = 0;
          if (!supplyOk) begin mSt = 0; mWd = 0; end
          else if (mArm && mTick && !mKick && mWd >= mLim - 1) begin mSt = 1; mWd = 0; end
          else if (mKick || !mArm) mWd = 0;
          else if (mTick) mWd++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && compareOn) begin
      check("R3/R5/R8 model", active() == (mSt != 2), "reset vs model", active(), (mSt != 2));
      check("R10", resetOutHi == !resetOutLo, "polarity pair", resetOutHi, !resetOutLo);
    end
  end

  task automatic waitFor(bit wantActive, int cap, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (active() != wantActive && n < cap);
  endtask

  task automatic kick();
    @(negedge clk) csWdi = 1'b1;
    @(negedge clk) csWdi = 1'b0;
  endtask

  task automatic tripAfterKick(bit endHigh, output int n);
    kick();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && endHigh) csWdi = 1'b1;
    end while (!active() && n < 1000);
  endtask

  task automatic quietFor(int cycles, output int bad);
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (active()) bad++;
    end
  endtask

  initial begin
    int n;
    int bad;
    bit found;
    void'($urandom(32'd7717));

    // R1 / R10: power-on reset state
    repeat (4) @(negedge clk);
    check("R1", active(), "reset during rstN", active(), 1);
    check("R10", resetOutHi == 1'b1, "active-high copy during rstN", resetOutHi, 1);
    @(negedge clk) rstN = 1'b1;
    compareOn = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", active(), "reset with supply low", active(), 1);

    // R3: hold after supply recovery
    @(negedge clk) supplyOk = 1'b1;
    waitFor(1'b0, 500, n);
    checkRange("R3", "hold after supply recovery", n, (H - 1) * DIV + 2, H * DIV + 1);

    // R4: regular kicks keep the block running
    wdPeriodSel = 2'b10;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      int b;
      kick();
      quietFor(6, b);
      bad += b;
    end
    check("R4", bad == 0, "cycles in reset while kicked", bad, 0);

    // R5 (line low), R8 hold length, R12 fresh period
    tripAfterKick(1'b0, n);
    checkRange("R5", "expiry with line held low", n, (WS - 1) * DIV + 2, WS * DIV + 1);
    waitFor(1'b0, 500, n);
    checkRange("R8", "watchdog reset length", n, (H - 1) * DIV + 1, H * DIV);
    waitFor(1'b1, 500, n);
    checkRange("R12", "full period after release", n, (WS - 1) * DIV + 1, WS * DIV);
    waitFor(1'b0, 500, n);

    // R5: line held high
    tripAfterKick(1'b1, n);
    checkRange("R5", "expiry with line held high", n, (WS - 1) * DIV + 2, WS * DIV + 1);
    waitFor(1'b0, 500, n);

    // R6: period codes
    wdPeriodSel = 2'b00;
    tripAfterKick(1'b0, n);
    checkRange("R6", "period code 00", n, (WL - 1) * DIV + 2, WL * DIV + 1);
    waitFor(1'b0, 500, n);
    wdPeriodSel = 2'b01;
    tripAfterKick(1'b0, n);
    checkRange("R6", "period code 01", n, (WM - 1) * DIV + 2, WM * DIV + 1);
    waitFor(1'b0, 500, n);
    wdPeriodSel = 2'b11;
    kick();
    quietFor(3 * WL * DIV, bad);
    check("R6", bad == 0, "code 11 disables watchdog", bad, 0);

    // R7: enable low
    wdPeriodSel = 2'b10;
    wdEnable = 1'b0;
    kick();
    quietFor(3 * WL * DIV, bad);
    check("R7", bad == 0, "watchdog disabled by enable", bad, 0);
    wdEnable = 1'b1;

    // R9: supply fault during a watchdog reset restarts the hold
    tripAfterKick(1'b0, n);
    repeat (3) @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    check("R9", active(), "reset during fault", active(), 1);
    supplyOk = 1'b1;
    waitFor(1'b0, 500, n);
    checkRange("R9", "full hold after fault in watchdog reset", n, (H - 1) * DIV + 2, H * DIV + 1);

    // R2: supply drop while running
    kick();
    @(negedge clk) supplyOk = 1'b0;
    @(negedge clk);
    check("R2", active(), "reset one cycle after drop", active(), 1);
    check("R10", resetOutHi == 1'b1, "active-high copy in fault", resetOutHi, 1);
    supplyOk = 1'b1;
    waitFor(1'b0, 500, n);

    // R11: kick in the very cycle of expiry
    kick();
    @(negedge clk) csWdi = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mSt == 2 && mWd == WS - 1 && mPre == DIV - 1) begin
        csWdi = 1'b0;
        found = 1'b1;
        break;
      end
    end
    check("R11", found, "expiry cycle reached", found, 1);
    waitFor(1'b1, 500, n);
    checkRange("R11", "kick at expiry starts a new period", n, (WS - 1) * DIV + 2, WS * DIV + 1);
    waitFor(1'b0, 500, n);

    // constrained random phase, judged against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 400 == 0) supplyOk = 1'b0;
      else if (!supplyOk && $urandom % 4 == 0) supplyOk = 1'b1;
      if ($urandom % 14 == 0) csWdi = ~csWdi;
      if ($urandom % 300 == 0) wdPeriodSel = 2'($urandom % 4);
      if ($urandom % 900 == 0) wdEnable = ~wdEnable;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule